// File: doc/BRIEF.md
# Secondary Interrupt Controller with Passthrough

This block gathers up to 32 interrupt sources into a single request for a primary interrupt controller. Each source bit is held in a level register. Hardware source lines update that register on their edges, and software can raise or drop bits through dedicated set and clear words. The level register is ANDed with an enable mask, and the OR of the result forms one combined request line. The system wires that line to the primary controller's top input.

A contiguous band of sources (21 to 30 by default) can also be routed past the combined line, so that each drives its own output. A primary input with the same number takes that output. Each source in the band has a passthrough-enable bit with its own set and clear words. Bits outside the band can never be enabled.

Software uses a simple register port. The port decodes a word index, which is bits 11:2 of a byte offset inside a 4 KB window. Every access produces exactly one response on the following cycle, carrying read data and an error flag. The register port has no back-pressure, so the block accepts an access in any cycle that `bus_sel` is high.

Top module: `irq_sec_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the level, mask and passthrough-enable registers. While these registers are clear, `irq_comb` and every bit of `irq_pass` are low.
- R2: Each source line is sampled on every clock. A rising line sets its level bit, and a falling line clears it. While the line is high, a software clear of that bit has no effect.
- R3: A write to word 4 ORs the write data into the level register. A write to word 5 clears the level bits that are set in the write data.
- R4: A write to word 2 ORs the write data into the mask. A write to word 3 clears the mask bits that are set in the write data. A read of word 2 returns the mask.
- R5: `irq_comb` is high exactly when (level AND mask) is non-zero, and it follows the registers without further delay.
- R6: A read of word 0 returns level AND mask, and a read of word 1 returns the raw level register. For every access, `rsp_valid` is high on the cycle after the access is accepted, and write responses carry zero data.
- R7: A write to word 8 sets passthrough-enable bits, but only bits 21 to 30 (mask 0x7FE00000). A write to word 9 clears the passthrough-enable bits that are set in the write data. A read of word 8 returns the register.
- R8: `irq_pass[i]` is high exactly when both passthrough-enable bit i and level bit i are set. Bits outside the band are always low.
- R9: Reads of word indices other than 0, 1, 2 and 8 return zero. Writes to word indices other than 2, 3, 4, 5, 8 and 9 change no register. In both cases, `rsp_err` is high in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Hardware interrupt source lines |
| bus_sel | input | 1 | Register access accepted this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 10 | Word index (byte offset bits 11:2) |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle for the previous access |
| rsp_data | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Previous access used an undefined word |
| irq_comb | output | 1 | Combined request to the primary controller |
| irq_pass | output | 32 | Per-source direct requests (band 21 to 30) |

## Verification
Register writes and source-line edges take effect at the clock edge that samples them. Both request outputs are driven combinationally from the registers, so they show the new state in the same cycle that follows that edge. Every response, including the error flag, appears exactly one cycle after the access. The bench drives stimulus on falling edges and samples on the next falling edge, so each result is read one full rising edge after its cause. Expected responses are queued when an access is issued and popped in order whenever `rsp_valid` is seen.

// File: rtl/irq_sec_pkg.sv
package irq_sec_pkg;
  localparam int WD_STAT = 0;
  localparam int WD_RAW  = 1;
  localparam int WD_MSET = 2;
  localparam int WD_MCLR = 3;
  localparam int WD_SSET = 4;
  localparam int WD_SCLR = 5;
  localparam int WD_PSET = 8;
  localparam int WD_PCLR = 9;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT,
    RD_RAW,
    RD_MASK,
    RD_PEN
  } rd_sel_e;

  typedef struct packed {
    logic mset;
    logic mclr;
    logic sset;
    logic sclr;
    logic pset;
    logic pclr;
  } wr_cmd_t;
endpackage

// File: rtl/irq_sec_decode.sv
module irq_sec_decode
  import irq_sec_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              sel,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  output wr_cmd_t           cmd,
  output rd_sel_e           rsel,
  output logic              bad
);
  always_comb begin
    cmd  = '0;
    rsel = RD_NONE;
    bad  = 1'b0;
    if (sel) begin
      if (we) begin
        case (word)
          WORD_W'(WD_MSET): cmd.mset = 1'b1;
          WORD_W'(WD_MCLR): cmd.mclr = 1'b1;
          WORD_W'(WD_SSET): cmd.sset = 1'b1;
          WORD_W'(WD_SCLR): cmd.sclr = 1'b1;
          WORD_W'(WD_PSET): cmd.pset = 1'b1;
          WORD_W'(WD_PCLR): cmd.pclr = 1'b1;
          default:          bad      = 1'b1;
        endcase
      end else begin
        case (word)
          WORD_W'(WD_STAT): rsel = RD_STAT;
          WORD_W'(WD_RAW):  rsel = RD_RAW;
          WORD_W'(WD_MSET): rsel = RD_MASK;
          WORD_W'(WD_PSET): rsel = RD_PEN;
          default:          bad  = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_sec_regs.sv
module irq_sec_regs
  import irq_sec_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  wr_cmd_t         cmd,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] lvl_q,
  output logic [NSRC-1:0] msk_q,
  output logic [NSRC-1:0] pen_q
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [NSRC-1:0] rise_v;
  logic [NSRC-1:0] fall_v;
  logic [NSRC-1:0] lvl_d;

  assign set_v  = cmd.sset ? wdata : '0;
  assign clr_v  = cmd.sclr ? wdata : '0;
  assign rise_v = src_in & ~src_q;
  assign fall_v = ~src_in & src_q;

  // Software first, then hardware edges; a high line shields its bit from clear.
  always_comb begin
    lvl_d = lvl_q | set_v;
    lvl_d = lvl_d & ~(clr_v & ~src_in);
    lvl_d = (lvl_d | rise_v) & ~fall_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      src_q <= '0;
      msk_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      src_q <= src_in;
      if (cmd.mset) msk_q <= msk_q | wdata;
      else if (cmd.mclr) msk_q <= msk_q & ~wdata;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_pen
    if (i >= PASS_LO && i <= PASS_HI) begin : g_band
      logic pen_bit;
      always_ff @(posedge clk) begin
        if (rst) pen_bit <= 1'b0;
        else if (cmd.pset && wdata[i]) pen_bit <= 1'b1;
        else if (cmd.pclr && wdata[i]) pen_bit <= 1'b0;
      end
      assign pen_q[i] = pen_bit;
    end else begin : g_off
      assign pen_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_sec_outgen.sv
module irq_sec_outgen #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] lvl_q,
  input  logic [NSRC-1:0] msk_q,
  input  logic [NSRC-1:0] pen_q,
  output logic [NSRC-1:0] status,
  output logic            irq_comb,
  output logic [NSRC-1:0] irq_pass
);
  assign status   = lvl_q & msk_q;
  assign irq_comb = |status;
  assign irq_pass = pen_q & lvl_q;
endmodule

// File: rtl/irq_sec_resp.sv
module irq_sec_resp
  import irq_sec_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            bad,
  input  rd_sel_e         rsel,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] lvl_q,
  input  logic [NSRC-1:0] msk_q,
  input  logic [NSRC-1:0] pen_q,
  output logic            rsp_valid,
  output logic [NSRC-1:0] rsp_data,
  output logic            rsp_err
);
  logic [NSRC-1:0] rd_mux;

  always_comb begin
    case (rsel)
      RD_STAT: rd_mux = status;
      RD_RAW:  rd_mux = lvl_q;
      RD_MASK: rd_mux = msk_q;
      RD_PEN:  rd_mux = pen_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sel;
      rsp_err   <= sel & bad;
      rsp_data  <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_sec_ctrl.sv
module irq_sec_ctrl
  import irq_sec_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int ADDR_W  = 12,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     src_in,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-3:0]   bus_word,
  input  logic [NSRC-1:0]     bus_wdata,
  output logic                rsp_valid,
  output logic [NSRC-1:0]     rsp_data,
  output logic                rsp_err,
  output logic                irq_comb,
  output logic [NSRC-1:0]     irq_pass
);
  localparam int WORD_W = ADDR_W - 2;

  wr_cmd_t         cmd;
  rd_sel_e         rsel;
  logic            bad;
  logic [NSRC-1:0] lvl_q;
  logic [NSRC-1:0] msk_q;
  logic [NSRC-1:0] pen_q;
  logic [NSRC-1:0] status;

  irq_sec_decode #(.WORD_W(WORD_W)) u_dec (
    .sel  (bus_sel),
    .we   (bus_we),
    .word (bus_word),
    .cmd  (cmd),
    .rsel (rsel),
    .bad  (bad)
  );

  irq_sec_regs #(.NSRC(NSRC), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .src_in (src_in),
    .cmd    (cmd),
    .wdata  (bus_wdata),
    .lvl_q  (lvl_q),
    .msk_q  (msk_q),
    .pen_q  (pen_q)
  );

  irq_sec_outgen #(.NSRC(NSRC)) u_out (
    .lvl_q    (lvl_q),
    .msk_q    (msk_q),
    .pen_q    (pen_q),
    .status   (status),
    .irq_comb (irq_comb),
    .irq_pass (irq_pass)
  );

  irq_sec_resp #(.NSRC(NSRC)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .sel       (bus_sel),
    .bad       (bad),
    .rsel      (rsel),
    .status    (status),
    .lvl_q     (lvl_q),
    .msk_q     (msk_q),
    .pen_q     (pen_q),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/irq_sec_chk.sv
module irq_sec_chk #(
  parameter int NSRC    = 32,
  parameter int WORD_W  = 10,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_in,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [WORD_W-1:0] bus_word,
  input logic [NSRC-1:0]   bus_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              irq_comb,
  input logic [NSRC-1:0]   irq_pass,
  input logic [NSRC-1:0]   lvl_q,
  input logic [NSRC-1:0]   msk_q,
  input logic [NSRC-1:0]   pen_q
);
  function automatic logic [NSRC-1:0] band_f();
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[i] = (i >= PASS_LO && i <= PASS_HI);
    return m;
  endfunction
  localparam logic [NSRC-1:0] BAND = band_f();

  logic wr_mset, wr_pclr;
  assign wr_mset = bus_sel && bus_we && bus_word == WORD_W'(2);
  assign wr_pclr = bus_sel && bus_we && bus_word == WORD_W'(9);

  // R1: the cycle after reset is seen, all state and the combined line are clear
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (lvl_q == '0 && msk_q == '0 && pen_q == '0 && !irq_comb));

  // R2: a line high at an edge leaves its level bit set after that edge
  assert_line_high_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lvl_q & $past(src_in)) == $past(src_in)));

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
    wr_mset |=> ((msk_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_comb_needs_src_R5: assert property (@(posedge clk) disable iff (rst)
    irq_comb |-> (lvl_q != '0 && msk_q != '0));

  assert_pen_band_R7: assert property (@(posedge clk) disable iff (rst)
    (pen_q & ~BAND) == '0);

  assert_pen_clear_R7: assert property (@(posedge clk) disable iff (rst)
    wr_pclr |=> ((pen_q & $past(bus_wdata)) == '0));

  assert_pass_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_pass & ~(pen_q & BAND)) == '0);

  assert_err_in_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
endmodule

bind irq_sec_ctrl irq_sec_chk #(
  .NSRC(NSRC), .WORD_W(ADDR_W - 2), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_in    (src_in),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_word  (bus_word),
  .bus_wdata (bus_wdata),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .irq_comb  (irq_comb),
  .irq_pass  (irq_pass),
  .lvl_q     (lvl_q),
  .msk_q     (msk_q),
  .pen_q     (pen_q)
);

// File: tb/irq_sec_ctrl_test.sv
module irq_sec_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_in;
  logic        bus_sel, bus_we;
  logic [9:0]  bus_word;
  logic [31:0] bus_wdata;
  logic        rsp_valid, rsp_err, irq_comb;
  logic [31:0] rsp_data, irq_pass;

  always #2 clk = ~clk;

  irq_sec_ctrl uut (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .irq_comb(irq_comb), .irq_pass(irq_pass)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_lvl = 0, m_msk = 0, m_pen = 0, m_src = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one queued expectation per response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rsp_data, e.data);
        check({e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
      end
    end
  end

  task automatic access(input bit we, input int w, input logic [31:0] d, input string tag);
    exp_t e;
    e.tag = tag;
    e.data = 32'd0;
    e.err = 1'b0;
    if (!we) begin
      case (w)
        0: e.data = m_lvl & m_msk;
        1: e.data = m_lvl;
        2: e.data = m_msk;
        8: e.data = m_pen;
        default: e.err = 1'b1;
      endcase
    end else if (!(w inside {2, 3, 4, 5, 8, 9})) begin
      e.err = 1'b1;
    end
    exp_q.push_back(e);
    bus_sel = 1'b1; bus_we = we; bus_word = 10'(w); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    if (we) begin
      case (w)
        2: m_msk = m_msk | d;
        3: m_msk = m_msk & ~d;
        4: m_lvl = m_lvl | d;
        5: m_lvl = m_lvl & ~(d & ~m_src);
        8: m_pen = m_pen | (d & 32'h7FE0_0000);
        9: m_pen = m_pen & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic set_src(input logic [31:0] v);
    src_in = v;
    @(negedge clk);
    m_lvl = (m_lvl | (v & ~m_src)) & ~(~v & m_src);
    m_src = v;
  endtask

  task automatic chk_out(input string tag);
    check({tag, " irq_comb"}, {31'd0, irq_comb}, {31'd0, |(m_lvl & m_msk)});
    check({tag, " irq_pass"}, irq_pass, m_pen & m_lvl);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    check("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    rst = 1'b1; src_in = '0; bus_sel = 1'b0; bus_we = 1'b0; bus_word = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_out("R1");
    access(0, 1, 0, "R1 level after reset");
    access(0, 2, 0, "R1 mask after reset");
    access(0, 8, 0, "R1 pen after reset");

    // R3 soft set, mask still clear
    access(1, 4, 32'h0000_00F0, "R3 soft set");
    access(0, 1, 0, "R3 raw level read");
    access(0, 0, 0, "R6 status with empty mask");
    chk_out("R5 masked off");

    // R4 mask set, R5 combined line
    access(1, 2, 32'h0000_0010, "R4 mask set");
    access(0, 2, 0, "R4 mask read");
    chk_out("R5 combined high");
    access(0, 0, 0, "R6 status read");

    // R3 soft clear
    access(1, 5, 32'h0000_0010, "R3 soft clear");
    chk_out("R5 combined low");
    access(0, 1, 0, "R3 level after clear");

    // R4 mask clear
    access(1, 3, 32'h0000_0010, "R4 mask clear");
    access(0, 2, 0, "R4 mask after clear");

    // R2 hardware edges and priority over soft clear
    set_src(32'h0000_0008);
    access(0, 1, 0, "R2 rise sets level");
    access(1, 5, 32'h0000_0008, "R2 clear while line high");
    access(0, 1, 0, "R2 level kept by high line");
    set_src(32'h0000_0000);
    access(0, 1, 0, "R2 fall clears level");

    // R7 passthrough band and R8 direct outputs
    access(1, 8, 32'hFFFF_FFFF, "R7 pen set all");
    access(0, 8, 0, "R7 pen only band");
    chk_out("R8 no band level");
    set_src(32'h0200_0000);
    chk_out("R8 source 25 forwarded");
    access(1, 4, 32'h0040_0020, "R8 soft set 22 and 5");
    chk_out("R8 band only");
    access(1, 9, 32'h0200_0000, "R7 pen clear 25");
    chk_out("R8 after pen clear");
    access(0, 8, 0, "R7 pen read after clear");

    // R9 undefined words
    access(0, 6, 0, "R9 undefined read");
    access(1, 7, 32'hFFFF_FFFF, "R9 undefined write");
    access(1, 1, 32'hFFFF_FFFF, "R9 write to read-only word");
    access(0, 1, 0, "R9 level untouched");
    access(0, 2, 0, "R9 mask untouched");
    access(0, 8, 0, "R9 pen untouched");
    chk_out("R9 outputs untouched");

    repeat (2) @(negedge clk);
    check("R6 responses outstanding", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule